// File: doc/BRIEF.md
# Bitwise logic unit with condition flags

This block is the logical half of a 32-bit integer execute stage. It takes a first operand and a second operand that an upstream barrel shifter has already shifted or rotated, together with the carry bit that the shifter produced. An opcode selects one of five bitwise functions: AND, OR, exclusive OR, AND with the second operand inverted, and OR with the second operand inverted. The block is purely combinational.

Alongside the result, the block produces the next value of the four condition flags: negative, zero, carry and overflow. When flag setting is requested, negative and zero are taken from the result. Carry is taken only from the shifter, and only when the shifter marks its carry as meaningful. Overflow is never touched. A condition-pass input comes from the condition evaluator. When the condition fails, the flags pass through untouched and the write enable to the register file stays low.

Top module: `bitwise_logic_unit`

## Requirements
- R1: With `op` = 3'd0 the result is `opa & opb`.
- R2: With `op` = 3'd1 the result is `opa | opb`.
- R3: With `op` = 3'd2 the result is `opa ^ opb`.
- R4: With `op` = 3'd3 the result is `opa & ~opb`.
- R5: With `op` = 3'd4 the result is `opa | ~opb`.
- R6: The reserved opcodes 3'd5, 3'd6 and 3'd7 give an all-zero result.
- R7: When `cond_ok` and `set_flags` are both high, the N flag of `flags_out` equals bit W-1 of the result. The flag vector layout is bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V, for both `flags_in` and `flags_out`.
- R8: When `cond_ok` and `set_flags` are both high, the Z flag (bit 2) is 1 exactly when the result is all zeros.
- R9: When `cond_ok` and `set_flags` are both high, the C flag (bit 1) equals `shc` if `shc_vld` is high, and otherwise equals the incoming C flag.
- R10: The V flag (bit 0) of `flags_out` always equals the V flag of `flags_in`, for every opcode and control combination.
- R11: When `set_flags` is low, `flags_out` equals `flags_in`.
- R12: When `cond_ok` is low, `flags_out` equals `flags_in`, whatever the value of `set_flags`.
- R13: `wr_en` is high exactly when `cond_ok` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W (32) | First operand |
| opb | input | W (32) | Second operand, already shifted |
| shc | input | 1 | Carry out of the operand-2 shifter |
| shc_vld | input | 1 | High when `shc` should load the C flag |
| op | input | 3 | Operation select |
| set_flags | input | 1 | Request to update the flags |
| cond_ok | input | 1 | Condition check passed |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | W (32) | Logic result |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| wr_en | output | 1 | Destination write qualifier |

## Verification
Every opcode, including the reserved ones, is driven with operand pairs drawn from eight patterns: all zeros, all ones, sign bit only, a mid byte, alternating halves, a mixed word, all-but-sign, and a single low bit.
- All-zero and all-ones pairings make each function produce zero or a full word, which separates a true Z from a stale Z.
- Sign-bit patterns separate an N taken from the result from an N taken from an operand.
- The inverted-operand functions are told apart from their plain forms by the asymmetric pairs.

Each pair is crossed with every combination of set-flags, condition pass, shifter carry, carry-valid and all sixteen incoming flag values. This makes a carry drawn from the wrong source, or any change to V, visible.

// File: rtl/blu_pkg.sv
package blu_pkg;

    localparam int FLAG_W = 4;
    localparam int OP_W   = 3;

    localparam logic [OP_W-1:0] OP_AND = 3'd0;
    localparam logic [OP_W-1:0] OP_ORR = 3'd1;
    localparam logic [OP_W-1:0] OP_EOR = 3'd2;
    localparam logic [OP_W-1:0] OP_BIC = 3'd3;
    localparam logic [OP_W-1:0] OP_ORN = 3'd4;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } blu_flags_t;

    typedef struct packed {
        logic set_flags;
        logic cond_ok;
        logic shc;
        logic shc_vld;
    } blu_ctrl_t;

    function automatic blu_flags_t flags_unpack(input logic [FLAG_W-1:0] raw);
        blu_flags_t f;
        f = blu_flags_t'(raw);
        return f;
    endfunction

    function automatic logic [FLAG_W-1:0] flags_pack(input blu_flags_t f);
        return {f.n, f.z, f.c, f.v};
    endfunction

endpackage

// File: rtl/blu_bitop.sv
module blu_bitop
    import blu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    y
);

    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_ORR:  y = a | b;
            OP_EOR:  y = a ^ b;
            OP_BIC:  y = a & ~b;
            OP_ORN:  y = a | ~b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/blu_zero_det.sv
module blu_zero_det #(
    parameter int W    = 32,
    parameter int LANE = 8
) (
    input  logic [W-1:0] v,
    output logic         zero
);

    localparam int NL  = (W + LANE - 1) / LANE;
    localparam int PW  = NL * LANE;

    logic [PW-1:0] padded;
    logic [NL-1:0] lane_any;

    assign padded = PW'(v);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign lane_any[i] = |padded[i*LANE +: LANE];
    end

    assign zero = ~|lane_any;

endmodule

// File: rtl/blu_flag_gen.sv
module blu_flag_gen
    import blu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic       msb,
    input  logic       zero,
    input  blu_ctrl_t  ctrl,
    input  blu_flags_t fin,
    output blu_flags_t fout
);

    logic upd;
    assign upd = ctrl.cond_ok & ctrl.set_flags;

    always_comb begin
        fout = fin;
        if (upd) begin
            fout.n = msb;
            fout.z = zero;
            if (ctrl.shc_vld) begin
                fout.c = ctrl.shc;
            end
        end
    end

endmodule

// File: rtl/bitwise_logic_unit.sv
module bitwise_logic_unit
    import blu_pkg::*;
#(
    parameter int W    = 32,
    parameter int LANE = 8
) (
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic              shc,
    input  logic              shc_vld,
    input  logic [OP_W-1:0]   op,
    input  logic              set_flags,
    input  logic              cond_ok,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [W-1:0]      result,
    output logic [FLAG_W-1:0] flags_out,
    output logic              wr_en
);

    blu_ctrl_t  ctrl;
    blu_flags_t fin;
    blu_flags_t fout;
    logic       zero;

    assign ctrl = '{set_flags: set_flags, cond_ok: cond_ok, shc: shc, shc_vld: shc_vld};
    assign fin  = flags_unpack(flags_in);

    blu_bitop #(.W(W)) u_bitop (
        .a  (opa),
        .b  (opb),
        .op (op),
        .y  (result)
    );

    blu_zero_det #(.W(W), .LANE(LANE)) u_zdet (
        .v    (result),
        .zero (zero)
    );

    blu_flag_gen #(.W(W)) u_fgen (
        .msb  (result[W-1]),
        .zero (zero),
        .ctrl (ctrl),
        .fin  (fin),
        .fout (fout)
    );

    assign flags_out = flags_pack(fout);
    assign wr_en     = ctrl.cond_ok;

endmodule

// File: rtl/blu_checker.sv
module blu_checker #(
    parameter int W = 32
) (
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         shc,
    input logic         shc_vld,
    input logic [2:0]   op,
    input logic         set_flags,
    input logic         cond_ok,
    input logic [3:0]   flags_in,
    input logic [W-1:0] result,
    input logic [3:0]   flags_out,
    input logic         wr_en
);

    always_comb begin
        a_r10_v_kept: assert (flags_out[0] == flags_in[0])
            else $error("V flag changed");
        if (!cond_ok) begin
            a_r12_cond_fail_hold: assert (flags_out == flags_in && !wr_en)
                else $error("flags or write changed on failed condition");
        end
        if (!set_flags) begin
            a_r11_no_sf_hold: assert (flags_out == flags_in)
                else $error("flags changed without set-flags");
        end
        if (cond_ok && set_flags) begin
            a_r7_n_msb: assert (flags_out[3] == result[W-1])
                else $error("N not from result sign");
            a_r8_z_zero: assert (flags_out[2] == (result == '0))
                else $error("Z mismatch");
            if (shc_vld) begin
                a_r9_c_shifter: assert (flags_out[1] == shc)
                    else $error("C not from shifter");
            end else begin
                a_r9_c_kept: assert (flags_out[1] == flags_in[1])
                    else $error("C changed without valid carry");
            end
        end
        if (op > 3'd4) begin
            a_r6_reserved_zero: assert (result == '0)
                else $error("reserved opcode nonzero");
        end
        if (op == 3'd3) begin
            a_r4_bic_clear: assert ((result & opb) == '0)
                else $error("BIC left a masked bit");
        end
    end

endmodule

bind bitwise_logic_unit blu_checker #(.W(W)) u_chk (
    .opa       (opa),
    .opb       (opb),
    .shc       (shc),
    .shc_vld   (shc_vld),
    .op        (op),
    .set_flags (set_flags),
    .cond_ok   (cond_ok),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out),
    .wr_en     (wr_en)
);

// File: tb/bitwise_logic_unit_tb.sv
module bitwise_logic_unit_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         shc = 1'b0;
    logic         shc_vld = 1'b0;
    logic [2:0]   op = 3'd0;
    logic         set_flags = 1'b0;
    logic         cond_ok = 1'b0;
    logic [3:0]   flags_in = 4'd0;
    logic [W-1:0] result;
    logic [3:0]   flags_out;
    logic         wr_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bitwise_logic_unit #(.W(W)) u_dut (
        .opa(opa), .opb(opb), .shc(shc), .shc_vld(shc_vld), .op(op),
        .set_flags(set_flags), .cond_ok(cond_ok), .flags_in(flags_in),
        .result(result), .flags_out(flags_out), .wr_en(wr_en)
    );

    function automatic logic [W-1:0] pat(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h0000_FF00;
            4: return 32'hAAAA_5555;
            5: return 32'h1234_5678;
            6: return 32'h7FFF_FFFF;
            default: return 32'h0000_0001;
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h sf=%b c=%b cv=%b sc=%b fin=%b: actual %h expected %h",
                     req, op, opa, opb, set_flags, cond_ok, shc_vld, shc, flags_in, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Idle inputs: all-zero state
        chk("R1", result, '0);
        chk("R12", {28'd0, flags_out}, '0);
        chk("R13", {31'd0, wr_en}, '0);

        for (int o = 0; o < 8; o++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    for (int c = 0; c < 256; c++) begin
                        logic [W-1:0] er;
                        logic [3:0]   ef;
                        string rq;
                        op        = 3'(o);
                        opa       = pat(ia);
                        opb       = pat(ib);
                        flags_in  = c[3:0];
                        set_flags = c[4];
                        cond_ok   = c[5];
                        shc_vld   = c[6];
                        shc       = c[7];
                        #2;
                        case (o)
                            0: begin er = opa & opb;  rq = "R1"; end
                            1: begin er = opa | opb;  rq = "R2"; end
                            2: begin er = opa ^ opb;  rq = "R3"; end
                            3: begin er = opa & ~opb; rq = "R4"; end
                            4: begin er = opa | ~opb; rq = "R5"; end
                            default: begin er = '0;   rq = "R6"; end
                        endcase
                        chk(rq, result, er);
                        ef = flags_in;
                        if (!cond_ok) begin
                            chk("R12", {28'd0, flags_out}, {28'd0, ef});
                        end else if (!set_flags) begin
                            chk("R11", {28'd0, flags_out}, {28'd0, ef});
                        end else begin
                            ef[3] = er[W-1];
                            ef[2] = (er == '0);
                            if (shc_vld) ef[1] = shc;
                            chk("R7", {31'd0, flags_out[3]}, {31'd0, ef[3]});
                            chk("R8", {31'd0, flags_out[2]}, {31'd0, ef[2]});
                            chk("R9", {31'd0, flags_out[1]}, {31'd0, ef[1]});
                        end
                        chk("R10", {31'd0, flags_out[0]}, {31'd0, flags_in[0]});
                        chk("R13", {31'd0, wr_en}, {31'd0, cond_ok});
                    end
                end
            end
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule